// File: doc/BRIEF.md
# Span Timing Reference and Backplane Frame-Sync Generator

This block produces the timing signals for a four-span T1/E1 framer interface. A three-bit source code picks one of six line-rate clock inputs: a free-running oscillator, the recovered clocks of spans 1 to 4, or an external sync input. The rising edges of the picked input are counted down to an 8 kHz square wave that an external PLL uses as its reference. The edge count per period is 193 for T1 line clocks at 1.544 MHz and 256 for E1 line clocks at 2.048 MHz. Whenever the source or the line mode changes, the divider restarts. The new output period therefore begins with a complete high phase and never with a runt.

The block is clocked by the 8.192 MHz backplane clock. All the framers share this clock, and the block derives a transmit frame pulse and a receive frame pulse from it once every 1024 clocks. Some framer silicon delivers its receive data half a clock late. For those parts, the receive pulse can be launched from the falling edge, half a clock ahead of the transmit pulse. The receiving side then samples with the inverted backplane clock that the block also outputs. When a mode input is set, the receive pulse is identical to the transmit pulse. Line clock inputs are asynchronous and are synchronised inside the block before edge detection.

Top module: `span_timing_gen`

## Requirements
- R1: `src_sel` picks the line clock input: code 0 is `line_clk_in[0]` (oscillator), codes 1 to 4 are `line_clk_in[1]` to `line_clk_in[4]` (spans 1 to 4), code 5 is `line_clk_in[5]` (external sync), and codes 6 and 7 fall back to `line_clk_in[0]`.
- R2: With `e1_mode` = 0, `ref_8k` stays high for 97 rising edges of the picked input and then low for 96, giving a 193-edge period.
- R3: With `e1_mode` = 1, `ref_8k` stays high for 128 rising edges and low for 128, giving a 256-edge period.
- R4: Activity on line clock inputs that are not picked has no effect on `ref_8k` or on the divider's phase.
- R5: A change of `src_sel` or `e1_mode` restarts the divider. `ref_8k` is high on the next clock, and a full high phase of the new mode follows.
- R6: `tx_fsync` is high for exactly one clock, once every 1024 clocks.
- R7: With `rx_align_tx` = 1, `rx_fsync` equals `tx_fsync` at all times.
- R8: With `rx_align_tx` = 0, `rx_fsync` rises and falls on the falling clock edge half a clock before `tx_fsync` rises and falls.
- R9: `rx_bp_clk_n` is the inverse of `clk`.
- R10: While `rst_n` is low, `ref_8k` is high and both frame pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.192 MHz backplane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk_in | input | 6 | Asynchronous line clocks: oscillator, spans 1-4, external sync |
| src_sel | input | 3 | Timing source code |
| e1_mode | input | 1 | 0 = T1 divisor 193, 1 = E1 divisor 256 |
| rx_align_tx | input | 1 | 1 = receive pulse equals transmit pulse, 0 = half-clock-early receive pulse |
| ref_8k | output | 1 | 8 kHz reference square wave |
| tx_fsync | output | 1 | Transmit frame pulse |
| rx_fsync | output | 1 | Receive frame pulse |
| rx_bp_clk_n | output | 1 | Inverted backplane clock for the receive side |

## Verification
Some properties are checked on every cycle. The reference output may only change on a counted edge or a restart. A restart always leaves it high. The divider count stays inside the active divisor. The transmit pulse is one clock wide and repeats every 1024 clocks. The receive pulse follows the transmit pulse in whichever mode is selected. Other properties need the bench's scenarios. These are the exact 97/96 and 128/128 phase lengths counted in edges of the picked input, the fallback of the unused codes, the immunity to the unpicked inputs, and the sub-cycle placement of the early receive pulse and the inverted clock.

// File: rtl/span_timing_pkg.sv
package span_timing_pkg;

  // Length of the high phase for a given divisor: the extra count of an odd divisor goes high.
  function automatic int unsigned high_len(input int unsigned divisor);
    return divisor - (divisor / 2);
  endfunction

  // Map a source code onto an existing input; codes past the last input fall back to input 0.
  function automatic int unsigned eff_source(input int unsigned code, input int unsigned num_src);
    return (code < num_src) ? code : 0;
  endfunction

endpackage

// File: rtl/src_select.sv
module src_select #(
  parameter int unsigned NUM_SRC     = 6,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] line_clk_in,
  input  logic [SEL_W-1:0]   src_sel,
  output logic               tick,
  output logic               sel_restart
);
  import span_timing_pkg::*;

  logic [NUM_SRC-1:0] synced;
  logic [SEL_W-1:0]   sel_q;
  logic [SEL_W-1:0]   eff;
  logic               picked;
  logic               picked_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], line_clk_in[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  always_comb begin
    eff    = SEL_W'(eff_source(int'(src_sel), NUM_SRC));
    picked = synced[eff];
  end

  assign sel_restart = (src_sel != sel_q);
  assign tick        = picked & ~picked_q & ~sel_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      picked_q <= 1'b0;
    end else begin
      sel_q    <= src_sel;
      picked_q <= picked;
    end
  end

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int unsigned T1_DIV = 193,
  parameter int unsigned E1_DIV = 256,
  parameter int unsigned CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sel_restart,
  input  logic             e1_mode,
  output logic             ref_8k,
  output logic             restart,
  output logic [CNT_W-1:0] div_cnt
);
  import span_timing_pkg::*;

  localparam logic [CNT_W-1:0] T1_LAST = CNT_W'(T1_DIV - 1);
  localparam logic [CNT_W-1:0] E1_LAST = CNT_W'(E1_DIV - 1);
  localparam logic [CNT_W:0]   T1_HIGH = (CNT_W+1)'(high_len(T1_DIV));
  localparam logic [CNT_W:0]   E1_HIGH = (CNT_W+1)'(high_len(E1_DIV));

  logic             e1_q;
  logic [CNT_W-1:0] last;
  logic [CNT_W:0]   high;
  logic [CNT_W-1:0] cnt_next;

  assign restart = sel_restart | (e1_mode != e1_q);

  always_comb begin
    last     = e1_mode ? E1_LAST : T1_LAST;
    high     = e1_mode ? E1_HIGH : T1_HIGH;
    cnt_next = (div_cnt == last) ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1_q    <= 1'b0;
      div_cnt <= '0;
      ref_8k  <= 1'b1;
    end else begin
      e1_q <= e1_mode;
      if (restart) begin
        div_cnt <= '0;
        ref_8k  <= 1'b1;
      end else if (tick) begin
        div_cnt <= cnt_next;
        ref_8k  <= ({1'b0, cnt_next} < high);
      end
    end
  end

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int unsigned FRAME_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_align_tx,
  output logic tx_fsync,
  output logic rx_fsync
);
  localparam int unsigned FW = $clog2(FRAME_LEN);
  localparam logic [FW-1:0] LAST = FW'(FRAME_LEN - 1);

  logic [FW-1:0] pos;
  logic          boundary;
  logic          rx_early;

  assign boundary = (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      tx_fsync <= 1'b0;
    end else begin
      pos      <= boundary ? '0 : pos + 1'b1;
      tx_fsync <= boundary;
    end
  end

  // Launched on the falling edge: leads the transmit pulse by half a clock.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_early <= 1'b0;
    else        rx_early <= boundary;
  end

  assign rx_fsync = rx_align_tx ? tx_fsync : rx_early;

endmodule

// File: rtl/span_timing_gen.sv
module span_timing_gen #(
  parameter int unsigned NUM_SRC     = 6,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned T1_DIV      = 193,
  parameter int unsigned E1_DIV      = 256,
  parameter int unsigned FRAME_LEN   = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] line_clk_in,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               e1_mode,
  input  logic               rx_align_tx,
  output logic               ref_8k,
  output logic               tx_fsync,
  output logic               rx_fsync,
  output logic               rx_bp_clk_n
);
  localparam int unsigned MAX_DIV = (T1_DIV > E1_DIV) ? T1_DIV : E1_DIV;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);

  logic             tick;
  logic             sel_restart;
  logic             div_restart;
  logic [CNT_W-1:0] div_cnt;

  src_select #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .line_clk_in(line_clk_in), .src_sel(src_sel),
    .tick(tick), .sel_restart(sel_restart)
  );

  ref_divider #(
    .T1_DIV(T1_DIV), .E1_DIV(E1_DIV), .CNT_W(CNT_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel_restart(sel_restart),
    .e1_mode(e1_mode), .ref_8k(ref_8k), .restart(div_restart), .div_cnt(div_cnt)
  );

  frame_sync_gen #(
    .FRAME_LEN(FRAME_LEN)
  ) u_frm (
    .clk(clk), .rst_n(rst_n), .rx_align_tx(rx_align_tx),
    .tx_fsync(tx_fsync), .rx_fsync(rx_fsync)
  );

  assign rx_bp_clk_n = ~clk;

endmodule

// File: rtl/span_timing_chk.sv
module span_timing_chk #(
  parameter int unsigned T1_DIV    = 193,
  parameter int unsigned E1_DIV    = 256,
  parameter int unsigned FRAME_LEN = 1024,
  parameter int unsigned CNT_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             restart,
  input logic [CNT_W-1:0] div_cnt,
  input logic             e1_mode,
  input logic             rx_align_tx,
  input logic             ref_8k,
  input logic             tx_fsync,
  input logic             rx_fsync
);
  localparam int unsigned GW = $clog2(FRAME_LEN) + 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(FRAME_LEN - 1);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      if (tx_fsync) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != {GW{1'b1}}) begin
        gap <= gap + 1'b1;
      end
    end
  end

  assert_ref_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(ref_8k));

  assert_restart_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ref_8k);

  assert_t1_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !e1_mode) |-> (int'(div_cnt) < T1_DIV));

  assert_e1_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && e1_mode) |-> (int'(div_cnt) < E1_DIV));

  assert_tx_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fsync |=> !tx_fsync);

  assert_tx_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fsync && seen) |-> (gap == GAP_LAST));

  assert_tx_not_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && gap < GAP_LAST) |-> !tx_fsync);

  assert_rx_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_align_tx |-> (rx_fsync == tx_fsync));

  assert_rx_leads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_align_tx && rx_fsync) |=> (rx_align_tx || tx_fsync));

endmodule

bind span_timing_gen span_timing_chk #(
  .T1_DIV(T1_DIV), .E1_DIV(E1_DIV), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .restart(div_restart), .div_cnt(div_cnt),
  .e1_mode(e1_mode), .rx_align_tx(rx_align_tx), .ref_8k(ref_8k),
  .tx_fsync(tx_fsync), .rx_fsync(rx_fsync)
);

// File: tb/span_timing_gen_test.sv
module span_timing_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] lines = '0;
  logic [2:0] src_sel = '0;
  logic       e1_mode = 1'b0;
  logic       rx_align_tx = 1'b1;
  logic       ref_8k, tx_fsync, rx_fsync, rx_bp_clk_n;

  int checks = 0;
  int failures = 0;
  logic [2:0] cur_sel = '0;
  logic       cur_e1 = 1'b0;

  always #2 clk = ~clk;

  span_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .line_clk_in(lines), .src_sel(src_sel),
    .e1_mode(e1_mode), .rx_align_tx(rx_align_tx), .ref_8k(ref_8k),
    .tx_fsync(tx_fsync), .rx_fsync(rx_fsync), .rx_bp_clk_n(rx_bp_clk_n)
  );

  function automatic int exp_high(input logic e1);
    int d = e1 ? 256 : 193;
    return (d + 1) / 2;
  endfunction

  function automatic int exp_low(input logic e1);
    int d = e1 ? 256 : 193;
    return d / 2;
  endfunction

  function automatic int driven_input(input logic [2:0] code);
    return (code > 3'd5) ? 0 : int'(code);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int idx);
    lines[idx] = 1'b1;
    step(); step();
    lines[idx] = 1'b0;
    step(); step();
  endtask

  // Select a source and mode, forcing a restart even if nothing changed.
  task automatic set_mode(input logic [2:0] sel, input logic e1);
    lines = '0;
    repeat (4) step();
    if (sel == cur_sel && e1 == cur_e1) begin
      src_sel = (sel == 3'd1) ? 3'd2 : 3'd1;
      step();
    end
    src_sel = sel;
    e1_mode = e1;
    cur_sel = sel;
    cur_e1  = e1;
    step();
    check(ref_8k == 1'b1, "R5 ref high after restart", int'(ref_8k), 1);
  endtask

  task automatic measure(input int idx, input int hi, input int lo, input string tag);
    int n = 0;
    int m = 0;
    while (ref_8k == 1'b1 && n < 600) begin
      pulse(idx);
      n++;
    end
    check(n == hi, {tag, " high phase edges"}, n, hi);
    while (ref_8k == 1'b0 && m < 600) begin
      pulse(idx);
      m++;
    end
    check(m == lo, {tag, " low phase edges"}, m, lo);
  endtask

  task automatic frame_run(input logic align);
    int cyc = 0;
    int last_rise = -1;
    int gaps_bad = 0;
    int gaps = 0;
    int width_bad = 0;
    int rel_bad = 0;
    int clk_bad = 0;
    logic prev_tx = 1'b0;
    logic prev_rx_late = 1'b0;
    logic tx_a, rx_a, tx_b, rx_b;
    rx_align_tx = align;
    step();
    for (int i = 0; i < 2200; i++) begin
      @(posedge clk);
      #1;
      tx_a = tx_fsync; rx_a = rx_fsync;
      if (rx_bp_clk_n != 1'b0) clk_bad++;
      if (tx_a && !prev_tx) begin
        if (last_rise >= 0) begin
          gaps++;
          if (cyc - last_rise != 1024) gaps_bad++;
        end
        last_rise = cyc;
      end
      if (tx_a && prev_tx) width_bad++;
      if (align) begin
        if (rx_a != tx_a) rel_bad++;
      end else begin
        if (i > 0 && prev_rx_late != tx_a) rel_bad++;
      end
      #2;
      tx_b = tx_fsync; rx_b = rx_fsync;
      if (rx_bp_clk_n != 1'b1) clk_bad++;
      if (align && rx_b != tx_b) rel_bad++;
      prev_tx = tx_a;
      prev_rx_late = rx_b;
      cyc++;
    end
    check(gaps >= 1 && gaps_bad == 0, "R6 frame period 1024", gaps_bad, 0);
    check(width_bad == 0, "R6 pulse one clock wide", width_bad, 0);
    if (align) check(rel_bad == 0, "R7 rx equals tx", rel_bad, 0);
    else       check(rel_bad == 0, "R8 rx leads tx by half clock", rel_bad, 0);
    check(clk_bad == 0, "R9 inverted clock", clk_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20917));
    repeat (3) step();
    // R10: reset state
    check(ref_8k == 1'b1, "R10 ref high in reset", int'(ref_8k), 1);
    check(tx_fsync == 1'b0, "R10 tx pulse low in reset", int'(tx_fsync), 0);
    check(rx_fsync == 1'b0, "R10 rx pulse low in reset", int'(rx_fsync), 0);
    rst_n = 1'b1;
    step();

    frame_run(1'b1);
    frame_run(1'b0);
    rx_align_tx = 1'b1;

    // R2 and R1: T1 on the oscillator, then each span and the external input
    for (int s = 0; s < 6; s++) begin
      set_mode(3'(s), 1'b0);
      measure(s, 97, 96, $sformatf("R1 R2 source %0d", s));
    end

    // R3: E1 on span 4
    set_mode(3'd4, 1'b1);
    measure(4, 128, 128, "R3 E1 span 4");

    // R1: codes past the last input fall back to the oscillator
    set_mode(3'd7, 1'b0);
    measure(0, 97, 96, "R1 code 7 fallback");

    // R4: unpicked inputs toggle, output and phase must not move
    set_mode(3'd2, 1'b0);
    begin
      int moved = 0;
      for (int k = 0; k < 240; k++) begin
        pulse((k % 5 >= 2) ? (k % 5) + 1 : k % 5);
        if (ref_8k != 1'b1) moved++;
      end
      check(moved == 0, "R4 unpicked inputs ignored", moved, 0);
    end
    measure(2, 97, 96, "R4 phase intact");

    // R5: mid-phase mode change and source change restart the divider
    set_mode(3'd3, 1'b0);
    for (int k = 0; k < 150; k++) pulse(3);
    check(ref_8k == 1'b0, "R5 in low phase before switch", int'(ref_8k), 0);
    set_mode(3'd3, 1'b1);
    measure(3, 128, 128, "R5 restart on mode change");
    for (int k = 0; k < 60; k++) pulse(3);
    set_mode(3'd1, 1'b1);
    measure(1, 128, 128, "R5 restart on source change");

    // Random source and mode picks
    for (int r = 0; r < 5; r++) begin
      logic [2:0] sel = 3'($urandom_range(0, 7));
      logic       e1  = 1'($urandom_range(0, 1));
      set_mode(sel, e1);
      measure(driven_input(sel), exp_high(e1), exp_low(e1),
              $sformatf("R1 R2 R3 random sel %0d e1 %0d", sel, e1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule